// File: doc/BRIEF.md
# IP-to-MAC Nibble Lookup Table

This block is a small content-addressable table that turns a 32-bit destination IPv4 address into the lowest four bits of an egress destination MAC address. Before traffic starts, it is filled from a stream of 64-bit configuration records. Each record is accepted on a valid/data load interface and written into the next slot, starting at slot 0. When the last slot is written, the table raises a ready flag and keeps it raised.

Once ready, the table answers one lookup per request. One cycle after a request it presents a result strobe, a hit flag, the 4-bit value, and the full 48-bit destination MAC. The MAC is the card's own 48-bit address with only its lowest nibble replaced by the looked-up value. If the same key is stored in several slots, the lowest-numbered slot supplies the result.

Top module: `mac_nib_cam`

## Requirements
- R1: After reset, `ready` is 0, no result strobe is raised, and the load pointer points at slot 0.
- R2: Each accepted load record is 64 bits. Bits 63:32 are the key, bits 31:4 are ignored, and bits 3:0 are the nibble. Records fill slots 0, 1, 2 and so on in order.
- R3: `ready` rises in the cycle after the record for the last slot (DEPTH-1, default 15) is accepted, and it stays high until reset.
- R4: While `ready` is 0, a lookup request raises no result strobe.
- R5: A lookup request accepted while `ready` is 1 raises `res_valid` for exactly one cycle, at the first clock edge after the request.
- R6: A request whose key equals a stored key gives `res_hit`=1 and that slot's nibble.
- R7: A request whose key matches no slot gives `res_hit`=0 and `res_nib`=0.
- R8: When several slots hold the same key, the nibble from the lowest-numbered of them is returned.
- R9: `res_mac` bits 47:4 equal `own_mac` bits 47:4, and bits 3:0 equal `res_nib`.
- R10: Load records presented after `ready` is 1 are ignored and do not change any lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load record is present |
| ld_data | input | 64 | Load record: key[63:32], reserved[31:4], nibble[3:0] |
| ready | output | 1 | Every slot is loaded; lookups are served |
| own_mac | input | 48 | The card's own MAC address |
| req_valid | input | 1 | Lookup request |
| req_ip | input | 32 | Destination IPv4 address to look up |
| res_valid | output | 1 | Result strobe, one cycle after an accepted request |
| res_hit | output | 1 | A slot matched |
| res_nib | output | 4 | Looked-up nibble, 0 on a miss |
| res_mac | output | 48 | Own MAC with the lowest nibble replaced |

## Verification
The table is loaded with distinct keys plus two pairs of duplicate keys that carry different nibbles. Lookups are then made with each of the following:
- a key from a single slot, including the first and the last slot;
- each duplicated key, which shows whether the lowest slot takes priority;
- addresses that differ from a stored key by one bit, which shows whether all 32 bits are compared;
- addresses absent from the table, which shows whether a miss returns zeros.

Lookups issued during loading, and load records offered after the table is full, show whether the ready gating works. The expected MAC is rebuilt in the bench from `own_mac` and the expected nibble.

// File: rtl/mac_nib_cam_pkg.sv
package mac_nib_cam_pkg;
  localparam int KEY_W = 32;
  localparam int NIB_W = 4;
  localparam int REC_W = 64;
  localparam int MAC_W = 48;

  typedef struct packed {
    logic             used;
    logic [KEY_W-1:0] key;
    logic [NIB_W-1:0] nib;
  } slot_t;

  function automatic logic [KEY_W-1:0] rec_key(input logic [REC_W-1:0] r);
    return r[REC_W-1 -: KEY_W];
  endfunction

  function automatic logic [NIB_W-1:0] rec_nib(input logic [REC_W-1:0] r);
    return r[NIB_W-1:0];
  endfunction

  function automatic logic [MAC_W-1:0] splice_mac(input logic [MAC_W-1:0] base,
                                                  input logic [NIB_W-1:0] nib);
    return {base[MAC_W-1:NIB_W], nib};
  endfunction
endpackage

// File: rtl/mac_nib_loader.sv
module mac_nib_loader #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             full
);
  logic [IDX_W-1:0] ptr;
  logic             last_wr;

  assign wr_en   = ld_valid && !full;
  assign wr_idx  = ptr;
  assign last_wr = wr_en && (ptr == IDX_W'(DEPTH-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      full <= 1'b0;
    end else if (wr_en) begin
      if (last_wr) full <= 1'b1;
      else         ptr  <= ptr + 1'b1;
    end
  end

  p_full_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
  p_full_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> full);
  p_no_write_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);
endmodule

// File: rtl/mac_nib_match.sv
module mac_nib_match
  import mac_nib_cam_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  slot_t            slots [DEPTH],
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [NIB_W-1:0] nib
);
  logic [DEPTH-1:0] match_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = slots[g].used && (slots[g].key == key);
  end

  always_comb begin
    hit = 1'b0;
    nib = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit = 1'b1;
        nib = slots[i].nib;
      end
    end
  end

  always_comb begin
    a_miss_zero_r7: assert (hit || nib == '0);
    a_hit_has_match_r6: assert (hit == (match_vec != '0));
  end
endmodule

// File: rtl/mac_nib_cam.sv
module mac_nib_cam
  import mac_nib_cam_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [REC_W-1:0] ld_data,
  output logic             ready,
  input  logic [MAC_W-1:0] own_mac,
  input  logic             req_valid,
  input  logic [KEY_W-1:0] req_ip,
  output logic             res_valid,
  output logic             res_hit,
  output logic [NIB_W-1:0] res_nib,
  output logic [MAC_W-1:0] res_mac
);
  slot_t            table_q [DEPTH];
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             full;
  logic             req_take;
  logic             m_hit;
  logic [NIB_W-1:0] m_nib;

  mac_nib_loader #(.DEPTH(DEPTH)) u_loader (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .full(full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        table_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        table_q[g].used <= 1'b1;
        table_q[g].key  <= rec_key(ld_data);
        table_q[g].nib  <= rec_nib(ld_data);
      end
    end
  end

  mac_nib_match #(.DEPTH(DEPTH)) u_match (
    .slots(table_q), .key(req_ip), .hit(m_hit), .nib(m_nib)
  );

  assign ready    = full;
  assign req_take = req_valid && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_nib   <= '0;
    end else begin
      res_valid <= req_take;
      if (req_take) begin
        res_hit <= m_hit;
        res_nib <= m_nib;
      end
    end
  end

  assign res_mac = splice_mac(own_mac, res_nib);

  p_strobe_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> res_valid);
  p_no_strobe_unready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ready) |=> !res_valid);
  p_miss_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_nib == '0);
  p_mac_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_mac[MAC_W-1:NIB_W] == own_mac[MAC_W-1:NIB_W]);
endmodule

// File: tb/mac_nib_cam_test.sv
module mac_nib_cam_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [47:0] OWN = 48'h0A_02_01_02_03_0C;

  logic clk = 0, rst_n = 0, ld_valid = 0, req_valid = 0;
  logic [63:0] ld_data = '0;
  logic [47:0] own_mac = OWN;
  logic [31:0] req_ip = '0;
  logic ready, res_valid, res_hit;
  logic [3:0] res_nib;
  logic [47:0] res_mac;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_nib_cam #(.DEPTH(DEPTH)) uut (.*);

  // Table contents: slot 5 duplicates slot 3, slot 12 duplicates slot 9.
  function automatic logic [31:0] key_of(int i);
    if (i == 5)  return key_of(3);
    if (i == 12) return key_of(9);
    return 32'hC0A8_0000 + 32'(i * 7 + 1);
  endfunction
  function automatic logic [3:0] nib_of(int i);
    return 4'(15 - i);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // A request is driven before an edge; the result is sampled at the following falling edge.
  task automatic lookup(string req, logic [31:0] ip, logic eh, logic [3:0] en);
    @(negedge clk); req_valid = 1; req_ip = ip;
    @(negedge clk); req_valid = 0;
    chk({req, " valid"}, 64'(res_valid), 64'(1'b1));
    chk({req, " hit"}, 64'(res_hit), 64'(eh));
    chk({req, " nib"}, 64'(res_nib), 64'(en));
    chk({req, " mac"}, 64'(res_mac), 64'({OWN[47:4], en}));
    @(negedge clk);
    chk({req, " one-cycle"}, 64'(res_valid), 64'(1'b0));
  endtask

  // Vector table: ip, expected hit, expected nibble.
  typedef struct packed { logic [31:0] ip; logic hit; logic [3:0] nib; } vec_t;
  localparam vec_t VECS [8] = '{
    '{32'hC0A8_0001, 1'b1, 4'd15},  // slot 0
    '{32'hC0A8_0008, 1'b1, 4'd14},  // slot 1
    '{32'hC0A8_0016, 1'b1, 4'd12},  // slot 3 (duplicate of 5, lowest wins)
    '{32'hC0A8_0040, 1'b1, 4'd6},   // slot 9 (duplicate of 12)
    '{32'hC0A8_006A, 1'b1, 4'd0},   // slot 15, last
    '{32'hC0A8_0002, 1'b0, 4'd0},   // miss
    '{32'h40A8_0001, 1'b0, 4'd0},   // top bit differs from slot 0
    '{32'h0000_0000, 1'b0, 4'd0}    // zero key
  };

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", 64'(ready), 0);
    chk("R1 res_valid", 64'(res_valid), 0);
    rst_n = 1;
    // R4: request before load
    @(negedge clk); req_valid = 1; req_ip = key_of(0);
    @(negedge clk); req_valid = 0;
    chk("R4 no strobe unready", 64'(res_valid), 0);
    // R2 load, with reserved bits full of junk
    for (int i = 0; i < DEPTH; i++) begin
      ld_valid = 1; ld_data = {key_of(i), 28'hFFF_FFF0 ^ 28'(i), nib_of(i)};
      if (i == 7) begin
        req_valid = 1; req_ip = key_of(0);
      end
      @(negedge clk);
      req_valid = 0;
      if (i == 7) chk("R4 no strobe during load", 64'(res_valid), 0);
      if (i < DEPTH-1) chk("R3 not ready early", 64'(ready), 0);
    end
    ld_valid = 0;
    chk("R3 ready after last", 64'(ready), 1);
    for (int v = 0; v < 8; v++)
      lookup($sformatf("R6/R7/R8/R9 vec%0d", v), VECS[v].ip, VECS[v].hit, VECS[v].nib);
    lookup("R2 slot 7", key_of(7), 1, nib_of(7));
    // R10: extra load of a new key and an overwrite attempt of slot 0
    @(negedge clk); ld_valid = 1; ld_data = {32'h0102_0304, 28'h0, 4'h9};
    @(negedge clk); ld_data = {key_of(0), 28'h0, 4'h3};
    @(negedge clk); ld_valid = 0;
    chk("R3 ready sticky", 64'(ready), 1);
    lookup("R10 extra key ignored", 32'h0102_0304, 0, 0);
    lookup("R10 slot0 unchanged", key_of(0), 1, nib_of(0));
    // R9 with a different own MAC
    own_mac = 48'hFFFF_FFFF_FFF5;
    @(negedge clk); req_valid = 1; req_ip = key_of(2);
    @(negedge clk); req_valid = 0;
    chk("R9 mac splice", 64'(res_mac), 64'({44'hFFF_FFFF_FFFF, nib_of(2)}));
    // R1: reset again
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk("R1 ready after reset", 64'(ready), 0);
    chk("R1 strobe after reset", 64'(res_valid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule